// File: doc/BRIEF.md
# Prioritised Memory Access Permission Checker

This block decides whether a single memory access may go ahead. It takes an access address, a byte count, the requested read/write/execute mask and a machine-mode flag. Against these it weighs a set of protection entries. Each entry supplies an inclusive lower and upper byte bound and a configuration byte. The entries are walked from index 0 upward, and the first entry that touches either the first or the last byte of the access settles the outcome. Two global policy bits change the rules: a lockdown bit, which switches to fixed permission tables indexed by a 4-bit code, and a whitelist bit, which makes unmatched accesses fail.

The result appears one cycle after a request strobe. A two-state controller tracks this. State `S_IDLE` moves to `S_RESP` when `req_valid` is high. `S_RESP` stays in `S_RESP` while further strobes arrive back to back, and returns to `S_IDLE` when the strobe drops. Outside `S_RESP` the result outputs read zero.

The bounds and configuration bytes are inputs; computing bounds and holding configuration state are left to the surrounding logic.

Top module: `pmpchk_top`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` was high. While `rsp_valid` is low, `rsp_allow` and `rsp_grant` are zero.
- R2: Configuration byte layout: bit 0 is R, bit 1 is W, bit 2 is X, bits [4:3] are the match mode, and bit 7 is the lock flag. An entry with match mode 0 is off and is skipped. An active entry contains a byte address b when lo <= b <= hi.
- R3: Among active entries that contain the first or the last byte of the access, the one with the lowest index alone decides the result.
- R4: If the deciding entry contains exactly one of the first byte (addr) and the last byte (addr+size-1), the access is refused with `rsp_allow` = 0.
- R5: A size of 0 is treated as WORD_BYTES bytes (4 by default).
- R6: With lockdown clear and a fully containing entry, the allowed mask is RWX for a machine-mode access to an unlocked entry. In every other case it is the entry's own R/W/X bits.
- R7: With lockdown set, a machine-mode access uses code {L,R,W,X} as follows. Codes 2, 3 and 14 give RW. Codes 9 and 10 give X. Codes 11 and 13 give RX. Codes 12 and 15 give R. All other codes give nothing.
- R8: With lockdown set, a non-machine access uses code {L,R,W,X} as follows. Code 7 gives RWX. Code 5 gives RX. Codes 3 and 6 give RW. Codes 2, 4 and 15 give R. Codes 1, 10 and 11 give X. All other codes give nothing.
- R9: Permission masks use bit 0 for R, bit 1 for W and bit 2 for X. On a full match, `rsp_grant` is 1 exactly when every requested bit is present in `rsp_allow`.
- R10: When no active entry touches the access and the whitelist bit is set, the result is allow 0 and grant 0.
- R11: When no entry matches, whitelist is clear and lockdown is set, a machine-mode access that does not request X gets allow RW and is granted. Any other access gets allow 0 and is refused.
- R12: When no entry matches and both policy bits are clear, machine mode gets allow RWX and is granted, and other modes get allow 0 and are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Address of the first byte |
| req_size | input | SZW | Byte count, 0 meaning one word |
| req_perm | input | 3 | Requested permissions {X,W,R} |
| req_mmode | input | 1 | Access is from machine mode |
| sec_lockdown | input | 1 | Lockdown policy bit |
| sec_whitelist | input | 1 | Deny-unmatched policy bit |
| ent_lo | input | N*AW | Inclusive lower bounds, entry i at [i*AW +: AW] |
| ent_hi | input | N*AW | Inclusive upper bounds, entry i at [i*AW +: AW] |
| ent_cfg | input | N*8 | Configuration bytes, entry i at [i*8 +: 8] |
| rsp_valid | output | 1 | Result valid |
| rsp_allow | output | 3 | Allowed permissions {X,W,R} |
| rsp_grant | output | 1 | Access granted |

## Verification
All three result outputs come from one register stage, so each verdict is due on the clock edge after the edge that sampled its strobe. The driver applies a request on a falling edge. At that moment it queues the expected value, which a reference model built from the requirements computes. The monitor compares on the next falling edge that shows `rsp_valid`, which is half a cycle after the result register loads. Entry contents and policy bits change only while no strobe is pending, so each queued verdict matches the inputs that the register actually sampled.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;

    localparam int CFG_R        = 0;
    localparam int CFG_W        = 1;
    localparam int CFG_X        = 2;
    localparam int CFG_MODE_LSB = 3;
    localparam int CFG_LOCK     = 7;

    typedef logic [2:0] perm_t;

    localparam perm_t P_NONE = 3'b000;
    localparam perm_t P_R    = 3'b001;
    localparam perm_t P_X    = 3'b100;
    localparam perm_t P_RW   = 3'b011;
    localparam perm_t P_RX   = 3'b101;
    localparam perm_t P_RWX  = 3'b111;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } state_t;

    function automatic logic entry_active(input logic [7:0] cfg);
        return cfg[CFG_MODE_LSB +: 2] != 2'b00;
    endfunction

    function automatic logic [3:0] lock_code(input logic [7:0] cfg);
        return {cfg[CFG_LOCK], cfg[CFG_R], cfg[CFG_W], cfg[CFG_X]};
    endfunction

    function automatic perm_t mach_table(input logic [3:0] code);
        perm_t p;
        case (code)
            4'd2, 4'd3, 4'd14: p = P_RW;
            4'd9, 4'd10:       p = P_X;
            4'd11, 4'd13:      p = P_RX;
            4'd12, 4'd15:      p = P_R;
            default:           p = P_NONE;
        endcase
        return p;
    endfunction

    function automatic perm_t user_table(input logic [3:0] code);
        perm_t p;
        case (code)
            4'd7:                p = P_RWX;
            4'd5:                p = P_RX;
            4'd3, 4'd6:          p = P_RW;
            4'd2, 4'd4, 4'd15:   p = P_R;
            4'd1, 4'd10, 4'd11:  p = P_X;
            default:             p = P_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pmpchk_range.sv
module pmpchk_range #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] first_byte,
    input  logic [AW-1:0] last_byte,
    output logic          first_in,
    output logic          last_in
);
    always_comb begin
        first_in = (first_byte >= lo) && (first_byte <= hi);
        last_in  = (last_byte  >= lo) && (last_byte  <= hi);
    end
endmodule

// File: rtl/pmpchk_select.sv
module pmpchk_select
    import pmpchk_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   first_in,
    input  logic [N-1:0]   last_in,
    input  logic [N*8-1:0] cfg_flat,
    input  logic           mmode,
    input  logic           lockdown,
    input  logic           whitelist,
    input  perm_t          want,
    output perm_t          allow,
    output logic           grant
);
    function automatic perm_t rule_allow(input logic [7:0] cfg, input logic mm,
                                         input logic lk);
        perm_t p;
        if (!lk) begin
            p = (mm && !cfg[CFG_LOCK]) ? P_RWX : cfg[CFG_X:CFG_R];
        end else if (mm) begin
            p = mach_table(lock_code(cfg));
        end else begin
            p = user_table(lock_code(cfg));
        end
        return p;
    endfunction

    logic       found;
    logic [7:0] c;

    always_comb begin
        found = 1'b0;
        allow = P_NONE;
        grant = 1'b0;
        c     = 8'h00;
        for (int i = 0; i < N; i++) begin
            c = cfg_flat[i*8 +: 8];
            if (!found && entry_active(c) && (first_in[i] || last_in[i])) begin
                found = 1'b1;
                if (first_in[i] && last_in[i]) begin
                    allow = rule_allow(c, mmode, lockdown);
                    grant = ((want & allow) == want);
                end else begin
                    allow = P_NONE;
                    grant = 1'b0;
                end
            end
        end
        if (!found) begin
            if (whitelist) begin
                allow = P_NONE;
                grant = 1'b0;
            end else if (lockdown) begin
                if (mmode && !want[CFG_X]) begin
                    allow = P_RW;
                    grant = 1'b1;
                end else begin
                    allow = P_NONE;
                    grant = 1'b0;
                end
            end else begin
                allow = mmode ? P_RWX : P_NONE;
                grant = mmode;
            end
        end
    end
endmodule

// File: rtl/pmpchk_top.sv
module pmpchk_top
    import pmpchk_pkg::*;
#(
    parameter int N          = 8,
    parameter int AW         = 32,
    parameter int SZW        = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [SZW-1:0]  req_size,
    input  logic [2:0]      req_perm,
    input  logic            req_mmode,
    input  logic            sec_lockdown,
    input  logic            sec_whitelist,
    input  logic [N*AW-1:0] ent_lo,
    input  logic [N*AW-1:0] ent_hi,
    input  logic [N*8-1:0]  ent_cfg,
    output logic            rsp_valid,
    output logic [2:0]      rsp_allow,
    output logic            rsp_grant
);
    localparam int PADW = AW - SZW;
    localparam logic [SZW-1:0] WORD_SZ = SZW'(WORD_BYTES);

    state_t          state_q;
    state_t          state_d;
    logic [SZW-1:0]  eff_size;
    logic [AW-1:0]   last_byte;
    logic [N-1:0]    first_in;
    logic [N-1:0]    last_in;
    perm_t           dec_allow;
    logic            dec_grant;

    always_comb begin
        eff_size  = (req_size == '0) ? WORD_SZ : req_size;
        last_byte = req_addr + {{PADW{1'b0}}, eff_size} - {{(AW-1){1'b0}}, 1'b1};
    end

    for (genvar g = 0; g < N; g++) begin : g_range
        pmpchk_range #(.AW(AW)) i_range (
            .lo         (ent_lo[g*AW +: AW]),
            .hi         (ent_hi[g*AW +: AW]),
            .first_byte (req_addr),
            .last_byte  (last_byte),
            .first_in   (first_in[g]),
            .last_in    (last_in[g])
        );
    end

    pmpchk_select #(.N(N)) i_select (
        .first_in  (first_in),
        .last_in   (last_in),
        .cfg_flat  (ent_cfg),
        .mmode     (req_mmode),
        .lockdown  (sec_lockdown),
        .whitelist (sec_whitelist),
        .want      (req_perm),
        .allow     (dec_allow),
        .grant     (dec_grant)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = req_valid ? S_RESP : S_IDLE;
            S_RESP:  state_d = req_valid ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_allow <= P_NONE;
            rsp_grant <= 1'b0;
        end else begin
            rsp_allow <= dec_allow;
            rsp_grant <= dec_grant;
        end
    end

    assign rsp_valid = (state_q == S_RESP);

endmodule

// File: rtl/pmpchk_checker.sv
module pmpchk_checker
    import pmpchk_pkg::*;
#(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic [2:0]     req_perm,
    input logic           sec_whitelist,
    input logic [N*8-1:0] ent_cfg,
    input logic           rsp_valid,
    input logic [2:0]     rsp_allow,
    input logic           rsp_grant
);
    logic none_active;

    always_comb begin
        none_active = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (ent_cfg[i*8 + CFG_MODE_LSB +: 2] != 2'b00) none_active = 1'b0;
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_allow == 3'b000 && !rsp_grant)); // R1
    AST_GRANT_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> ((rsp_allow & $past(req_perm)) == $past(req_perm))); // R9
    AST_WHITELIST_EMPTY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_whitelist && none_active) |=> (rsp_allow == 3'b000 && !rsp_grant)); // R10
endmodule

bind pmpchk_top pmpchk_checker #(.N(N)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_perm      (req_perm),
    .sec_whitelist (sec_whitelist),
    .ent_cfg       (ent_cfg),
    .rsp_valid     (rsp_valid),
    .rsp_allow     (rsp_allow),
    .rsp_grant     (rsp_grant)
);

// File: tb/test_pmpchk_top.sv
module test_pmpchk_top;
    localparam int N = 8;
    localparam int AW = 32;
    localparam int SZW = 4;

    // lockdown tables as per-bit code masks (bit index = {L,R,W,X} code)
    localparam logic [15:0] M_R = 16'hF80C, M_W = 16'h400C, M_X = 16'h2E00;
    localparam logic [15:0] U_R = 16'h80FC, U_W = 16'h00C8, U_X = 16'h0CA2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SZW-1:0] req_size = '0;
    logic [2:0] req_perm = '0;
    logic req_mmode = 1'b0;
    logic sec_lockdown = 1'b0;
    logic sec_whitelist = 1'b0;
    logic [N*AW-1:0] ent_lo;
    logic [N*AW-1:0] ent_hi;
    logic [N*8-1:0] ent_cfg;
    logic rsp_valid;
    logic [2:0] rsp_allow;
    logic rsp_grant;

    logic [AW-1:0] lo_a [N];
    logic [AW-1:0] hi_a [N];
    logic [7:0] cfg_a [N];

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [3:0] exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_lo[i*AW +: AW] = lo_a[i];
            ent_hi[i*AW +: AW] = hi_a[i];
            ent_cfg[i*8 +: 8] = cfg_a[i];
        end
    end

    pmpchk_top #(.N(N), .AW(AW), .SZW(SZW), .WORD_BYTES(4)) i_pmpchk_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
        .sec_lockdown(sec_lockdown), .sec_whitelist(sec_whitelist),
        .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_grant(rsp_grant)
    );

    // reference model: returns {grant, allow}
    function automatic logic [3:0] ref_eval(input logic [AW-1:0] a, input logic [SZW-1:0] sz,
                                            input logic [2:0] p, input logic mm,
                                            input logic lk, input logic wl);
        logic [AW-1:0] last;
        logic [2:0] al;
        logic ok, hit, fin, lin;
        logic [3:0] code;
        last = a + ((sz == 0) ? 32'd4 : {28'd0, sz}) - 32'd1;
        hit = 0; al = 0; ok = 0;
        for (int i = 0; i < N; i++) begin
            fin = (a >= lo_a[i]) && (a <= hi_a[i]);
            lin = (last >= lo_a[i]) && (last <= hi_a[i]);
            if (!hit && cfg_a[i][4:3] != 0 && (fin || lin)) begin
                hit = 1;
                if (fin != lin) begin
                    al = 0; ok = 0;
                end else begin
                    code = {cfg_a[i][7], cfg_a[i][0], cfg_a[i][1], cfg_a[i][2]};
                    if (!lk) al = (mm && !cfg_a[i][7]) ? 3'b111 : cfg_a[i][2:0];
                    else if (mm) al = {M_X[code], M_W[code], M_R[code]};
                    else al = {U_X[code], U_W[code], U_R[code]};
                    ok = ((p & al) == p);
                end
            end
        end
        if (!hit) begin
            if (wl) begin al = 0; ok = 0; end
            else if (lk) begin ok = mm && !p[2]; al = ok ? 3'b011 : 3'b000; end
            else begin ok = mm; al = mm ? 3'b111 : 3'b000; end
        end
        return {ok, al};
    endfunction

    task automatic issue(input logic [AW-1:0] a, input logic [SZW-1:0] sz, input logic [2:0] p,
                         input logic mm, input logic lk, input logic wl, input string tag);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = sz; req_perm = p;
        req_mmode = mm; sec_lockdown = lk; sec_whitelist = wl;
        exp_q.push_back(ref_eval(a, sz, p, mm, lk, wl));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic set_ent(input int i, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                           input logic [7:0] cfg);
        lo_a[i] = lo; hi_a[i] = hi; cfg_a[i] = cfg;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected rsp_valid: actual 1 expected 0");
                end else begin
                    logic [3:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({rsp_grant, rsp_allow} !== e) begin
                        fails++;
                        $display("FAIL %s grant/allow: actual %b/%b expected %b/%b",
                                 t, rsp_grant, rsp_allow, e[3], e[2:0]);
                    end
                end
            end else if (rsp_allow !== 3'b000 || rsp_grant !== 1'b0) begin
                checks++;
                fails++;
                $display("FAIL R1 idle outputs: actual %b/%b expected 0/000", rsp_grant, rsp_allow);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) set_ent(i, 32'hFFFF_FFFF, 32'h0, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 0 || rsp_allow !== 0 || rsp_grant !== 0) begin
            fails++;
            $display("FAIL R1 reset state: actual %b%b%b expected 0000", rsp_valid, rsp_grant, rsp_allow);
        end

        // defaults with no active entries
        issue(32'h40, 4, 3'b111, 1, 0, 0, "R12 machine default");
        issue(32'h40, 4, 3'b001, 0, 0, 0, "R12 user default");
        issue(32'h40, 4, 3'b001, 1, 0, 1, "R10 whitelist");
        issue(32'h40, 4, 3'b011, 1, 1, 0, "R11 lockdown machine RW");
        issue(32'h40, 4, 3'b100, 1, 1, 0, "R11 lockdown machine X");
        issue(32'h40, 4, 3'b001, 0, 1, 0, "R11 lockdown user");
        idle();

        // overlapping entries: e0 R-only inside e1 RWX
        set_ent(0, 32'h100, 32'h1FF, 8'h09);
        set_ent(1, 32'h000, 32'hFFF, 8'h0F);
        issue(32'h180, 4, 3'b010, 0, 0, 0, "R3 lowest index wins");
        issue(32'h800, 4, 3'b010, 0, 0, 0, "R3 second entry");
        issue(32'h180, 4, 3'b010, 1, 0, 0, "R6 machine unlocked");
        issue(32'h180, 4, 3'b011, 0, 0, 0, "R9 subset fails");
        issue(32'h1FE, 4, 3'b001, 0, 0, 0, "R4 straddle top");
        issue(32'h0FE, 4, 3'b001, 1, 0, 0, "R4 straddle bottom");
        issue(32'h1FD, 0, 3'b001, 0, 0, 0, "R5 size zero straddles");
        issue(32'h1FC, 0, 3'b001, 0, 0, 0, "R5 size zero fits");
        issue(32'h1FF, 1, 3'b001, 0, 0, 0, "R2 inclusive upper bound");
        issue(32'h2000, 4, 3'b001, 1, 0, 1, "R10 whitelist miss");
        idle();

        set_ent(0, 32'h100, 32'h1FF, 8'h89);
        issue(32'h180, 4, 3'b010, 1, 0, 0, "R6 machine locked");
        issue(32'h180, 4, 3'b001, 1, 0, 0, "R6 machine locked read");
        idle();

        set_ent(0, 32'h100, 32'h1FF, 8'h01);
        issue(32'h180, 4, 3'b010, 0, 0, 0, "R2 off entry skipped");
        idle();

        // lockdown table sweep on entry 0
        for (int code = 0; code < 16; code++) begin
            logic [3:0] cd;
            cd = 4'(code);
            set_ent(0, 32'h100, 32'h1FF, {cd[3], 2'b00, 2'b01, cd[0], cd[1], cd[2]});
            issue(32'h140, 4, 3'b001, 1, 1, 0, "R7 machine table R");
            issue(32'h140, 4, 3'b100, 1, 1, 0, "R7 machine table X");
            issue(32'h140, 4, 3'b001, 0, 1, 0, "R8 user table R");
            issue(32'h140, 4, 3'b110, 0, 1, 0, "R8 user table WX");
            idle();
        end

        repeat (4) idle();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule